// File: doc/BRIEF.md
# Multichannel ADC Sample Interleaver

This block takes a set of four simultaneous 12-bit signed ADC samples, one per channel, on each pulse of a sample strobe. The four channels sit on two converter modules: channels 0 and 1 on the first module, channels 2 and 3 on the second. Each sample is widened to a 16-bit word. The upper four bits of the word carry sign extension, digital input bits, an overrange flag, or a mix of these, as set by two mode inputs. The words of the enabled channels leave the block as one valid/ready stream.

The stream order interleaves the two modules. All first enabled channels, taken module by module, come before any second enabled channel. With all four channels on, one sample set leaves as channel 0, 2, 1, 3. The channel mask may select one, two or all four channels. Any other mask is refused and a flag reports it. Configuration is read only while no set is draining. A strobe that arrives while a set is still draining is dropped and marks a sticky overflow flag.

Top module: `adc_word_interleaver`

## Requirements
- R1: A mask is legal when it has exactly one, two or four bits set. While idle, `config_error` shows one cycle later whether the present mask is illegal (1) or legal (0). A strobe that meets an illegal mask produces no words.
- R2: With one channel enabled, each sample set produces exactly one word, from that channel.
- R3: With two channels enabled, each set produces two words, and the lower-indexed channel comes first.
- R4: With all four channels enabled, each set produces four words in channel order 0, 2, 1, 3.
- R5: Bits 11:0 of every word hold the channel's 12-bit two's complement sample unchanged.
- R6: Standard mode (digital off, overrange off): bits 15:12 all equal sample bit 11.
- R7: Digital on, overrange off: bits 15:12 equal the channel's digital input bits 3:0.
- R8: Overrange on, digital off: bit 15 is the channel's overrange flag, and bits 14:12 equal sample bit 11.
- R9: Both on: bit 15 is the overrange flag, and bits 14:12 equal digital input bits 2:0.
- R10: Mask and mode changes made while a set is draining do not affect that set's words or count.
- R11: A strobe while `out_valid` is high sets `overflow` on the next cycle. The flag stays set until reset. The set that was draining completes unchanged, and the dropped set produces no words.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R13: After reset, `out_valid`, `config_error` and `overflow` are low. The first word of a set is valid in the cycle after the strobe edge, and every set starts again at its first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chan_en | input | 4 | Channel enable mask, bit i for channel i |
| cfg_dig_en | input | 1 | Digital input bits placed in upper word bits |
| cfg_ovr_en | input | 1 | Overrange flag placed in word bit 15 |
| smp_strobe | input | 1 | One-cycle pulse: a sample set is present |
| smp_data | input | 48 | Samples, channel i at bits 12i+11:12i |
| smp_dig | input | 16 | Digital inputs, channel i at bits 4i+3:4i |
| smp_ovr | input | 4 | Overrange flags, bit i for channel i |
| out_data | output | 16 | Packed output word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the word |
| config_error | output | 1 | Idle mask is illegal |
| overflow | output | 1 | Sticky: a set was dropped |

## Verification
The hardest case to reach is a strobe that lands while a set is still draining. With an always-ready consumer, a four-word set drains in four cycles, so the window is narrow. The bench holds `out_ready` low after the first strobe and then pulses a second strobe with different samples. It checks that the flag rises and that the stalled words still belong to the first set. A second hard case is a configuration change in the middle of a set. The bench changes both the mask and the mode while the set is stalled, then checks that the drained words keep the old mode and count.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ilv_state_t;

endpackage

// File: rtl/ilv_word_pack.sv
module ilv_word_pack #(
    parameter int SMP_W  = 12,
    parameter int WORD_W = 16,
    parameter int DIG_W  = 4
) (
    input  logic [SMP_W-1:0]  sample,
    input  logic [DIG_W-1:0]  dig,
    input  logic              ovr,
    input  logic              dig_en,
    input  logic              ovr_en,
    output logic [WORD_W-1:0] word
);
    localparam int EXT_W = WORD_W - SMP_W;

    logic sign;
    assign sign = sample[SMP_W-1];

    always_comb begin
        unique case ({ovr_en, dig_en})
            2'b00:   word = {{EXT_W{sign}}, sample};
            2'b01:   word = {dig[EXT_W-1:0], sample};
            2'b10:   word = {ovr, {(EXT_W-1){sign}}, sample};
            default: word = {ovr, dig[EXT_W-2:0], sample};
        endcase
    end

endmodule

// File: rtl/ilv_slot_plan.sv
module ilv_slot_plan #(
    parameter int NUM_CH     = 4,
    parameter int CH_PER_MOD = 2,
    parameter int CH_W       = $clog2(NUM_CH),
    parameter int CNT_W      = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_CH-1:0]           mask,
    output logic                        legal,
    output logic [CNT_W-1:0]            count,
    output logic [NUM_CH-1:0][CH_W-1:0] order
);
    localparam int NUM_MOD = NUM_CH / CH_PER_MOD;

    always_comb begin
        int cnt;
        int idx;
        cnt = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            cnt += int'(mask[c]);
        end
        count = CNT_W'(cnt);
        legal = (cnt == 1) || (cnt == 2) || (cnt == NUM_CH);

        order = '0;
        idx   = 0;
        for (int r = 0; r < CH_PER_MOD; r++) begin
            for (int m = 0; m < NUM_MOD; m++) begin
                int seen;
                seen = 0;
                for (int k = 0; k < CH_PER_MOD; k++) begin
                    if (mask[m*CH_PER_MOD + k]) begin
                        if (seen == r && idx < NUM_CH) begin
                            order[idx] = CH_W'(m*CH_PER_MOD + k);
                            idx++;
                        end
                        seen++;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adc_word_interleaver.sv
module adc_word_interleaver #(
    parameter int NUM_CH     = 4,
    parameter int CH_PER_MOD = 2,
    parameter int SMP_W      = 12,
    parameter int WORD_W     = 16,
    parameter int DIG_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         cfg_chan_en,
    input  logic                      cfg_dig_en,
    input  logic                      cfg_ovr_en,
    input  logic                      smp_strobe,
    input  logic [NUM_CH*SMP_W-1:0]   smp_data,
    input  logic [NUM_CH*DIG_W-1:0]   smp_dig,
    input  logic [NUM_CH-1:0]         smp_ovr,
    output logic [WORD_W-1:0]         out_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic                      config_error,
    output logic                      overflow
);
    import ilv_pkg::*;

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = $clog2(NUM_CH + 1);

    typedef struct packed {
        ilv_state_t                   st;
        logic [CNT_W-1:0]             slot;
        logic [CNT_W-1:0]             nslots;
        logic [NUM_CH-1:0][CH_W-1:0]  order;
        logic [NUM_CH-1:0][WORD_W-1:0] words;
        logic                         err;
        logic                         ovf;
    } regs_t;

    regs_t r_q, r_d;

    logic [NUM_CH-1:0][WORD_W-1:0] packed_w;
    logic [NUM_CH-1:0][CH_W-1:0]   plan_order;
    logic [CNT_W-1:0]              plan_count;
    logic                          plan_legal;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
        ilv_word_pack #(
            .SMP_W (SMP_W),
            .WORD_W(WORD_W),
            .DIG_W (DIG_W)
        ) u_pack (
            .sample(smp_data[c*SMP_W +: SMP_W]),
            .dig   (smp_dig[c*DIG_W +: DIG_W]),
            .ovr   (smp_ovr[c]),
            .dig_en(cfg_dig_en),
            .ovr_en(cfg_ovr_en),
            .word  (packed_w[c])
        );
    end

    ilv_slot_plan #(
        .NUM_CH    (NUM_CH),
        .CH_PER_MOD(CH_PER_MOD),
        .CH_W      (CH_W),
        .CNT_W     (CNT_W)
    ) u_plan (
        .mask (cfg_chan_en),
        .legal(plan_legal),
        .count(plan_count),
        .order(plan_order)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.err = !plan_legal;
                if (smp_strobe && plan_legal) begin
                    r_d.st     = ST_BUSY;
                    r_d.slot   = '0;
                    r_d.nslots = plan_count;
                    r_d.order  = plan_order;
                    r_d.words  = packed_w;
                end
            end
            default: begin
                if (smp_strobe) begin
                    r_d.ovf = 1'b1;
                end
                if (out_ready) begin
                    if (r_q.slot + CNT_W'(1) == r_q.nslots) begin
                        r_d.st   = ST_IDLE;
                        r_d.slot = '0;
                    end else begin
                        r_d.slot = r_q.slot + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid    = (r_q.st == ST_BUSY);
    assign out_data     = r_q.words[r_q.order[r_q.slot[CH_W-1:0]]];
    assign config_error = r_q.err;
    assign overflow     = r_q.ovf;

endmodule

// File: rtl/adc_word_interleaver_chk.sv
module adc_word_interleaver_chk #(
    parameter int NUM_CH     = 4,
    parameter int CH_PER_MOD = 2,
    parameter int SMP_W      = 12,
    parameter int WORD_W     = 16,
    parameter int DIG_W      = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   cfg_chan_en,
    input logic                smp_strobe,
    input logic [WORD_W-1:0]   out_data,
    input logic                out_valid,
    input logic                out_ready,
    input logic                config_error,
    input logic                overflow
);
    logic mask_ok;
    assign mask_ok = ($countones(cfg_chan_en) == 1) || ($countones(cfg_chan_en) == 2)
                   || ($countones(cfg_chan_en) == NUM_CH);

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R12

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R11

    AST_OVERFLOW_ON_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && smp_strobe) |=> overflow); // R11

    AST_NO_START_ON_BAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !mask_ok) |=> !out_valid); // R1

    AST_ERR_TRACKS_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (config_error == !$past(mask_ok))); // R1

    AST_START_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && mask_ok && smp_strobe) |=> out_valid); // R13

endmodule

bind adc_word_interleaver adc_word_interleaver_chk #(
    .NUM_CH    (NUM_CH),
    .CH_PER_MOD(CH_PER_MOD),
    .SMP_W     (SMP_W),
    .WORD_W    (WORD_W),
    .DIG_W     (DIG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_chan_en (cfg_chan_en),
    .smp_strobe  (smp_strobe),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .config_error(config_error),
    .overflow    (overflow)
);

// File: tb/adc_word_interleaver_test.sv
module adc_word_interleaver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_chan_en = 4'b1111;
    logic        cfg_dig_en = 1'b0;
    logic        cfg_ovr_en = 1'b0;
    logic        smp_strobe = 1'b0;
    logic [47:0] smp_data;
    logic [15:0] smp_dig;
    logic [3:0]  smp_ovr;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        config_error;
    logic        overflow;

    logic [11:0] smp [4];
    logic [3:0]  dg  [4];
    logic        ov  [4];
    logic [15:0] expw [4];
    int          exp_n;
    int          compared = 0;
    int          mismatched = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            smp_data[c*12 +: 12] = smp[c];
            smp_dig[c*4 +: 4]    = dg[c];
            smp_ovr[c]           = ov[c];
        end
    end

    adc_word_interleaver uut (
        .clk(clk), .rst_n(rst_n), .cfg_chan_en(cfg_chan_en),
        .cfg_dig_en(cfg_dig_en), .cfg_ovr_en(cfg_ovr_en),
        .smp_strobe(smp_strobe), .smp_data(smp_data), .smp_dig(smp_dig),
        .smp_ovr(smp_ovr), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .config_error(config_error), .overflow(overflow)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_word(logic [11:0] s, logic [3:0] d, logic o,
                                             logic den, logic oen);
        logic [15:0] w;
        w[11:0] = s;
        if (!den && !oen)      w[15:12] = {4{s[11]}};
        else if (den && !oen)  w[15:12] = d;
        else if (!den && oen)  w[15:12] = {o, {3{s[11]}}};
        else                   w[15:12] = {o, d[2:0]};
        return w;
    endfunction

    task automatic load_set(int seed);
        for (int c = 0; c < 4; c++) begin
            smp[c] = 12'((seed * 37 + c * 521 + 3) % 4096);
            dg[c]  = 4'((seed + c * 5) % 16);
            ov[c]  = 1'((seed + c) % 2);
        end
    endtask

    task automatic build_expect(logic [3:0] m, logic den, logic oen);
        int ord [4];
        exp_n = 0;
        if (m == 4'b1111) begin
            ord[0] = 0; ord[1] = 2; ord[2] = 1; ord[3] = 3; exp_n = 4;
        end else begin
            for (int c = 0; c < 4; c++) if (m[c]) begin ord[exp_n] = c; exp_n++; end
        end
        for (int i = 0; i < exp_n; i++)
            expw[i] = ref_word(smp[ord[i]], dg[ord[i]], ov[ord[i]], den, oen);
    endtask

    task automatic pulse_strobe();
        smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    task automatic drain_check(string req);
        for (int i = 0; i < exp_n; i++) begin
            chk({req, " valid"}, out_valid, 1);
            chk({req, " word"}, out_data, expw[i]);
            @(negedge clk);
        end
        chk({req, " end of set"}, out_valid, 0);
    endtask

    task automatic run_set(string req, logic [3:0] m, logic den, logic oen, int seed);
        cfg_chan_en = m; cfg_dig_en = den; cfg_ovr_en = oen;
        load_set(seed);
        @(negedge clk);
        build_expect(m, den, oen);
        pulse_strobe();
        drain_check(req);
    endtask

    task automatic t_reset();
        chk("R13 reset valid", out_valid, 0);
        chk("R13 reset config_error", config_error, 0);
        chk("R13 reset overflow", overflow, 0);
    endtask

    task automatic t_single();
        for (int c = 0; c < 4; c++) begin
            run_set("R2 single", 4'(1 << c), 1'b0, 1'b0, c + 1);
            run_set("R13 R2 next set", 4'(1 << c), 1'b0, 1'b0, c + 9);
        end
    endtask

    task automatic t_pairs();
        for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
                run_set("R3 pair", 4'((1 << a) | (1 << b)), 1'b0, 1'b0, a * 4 + b);
    endtask

    task automatic t_four_modes();
        run_set("R4 R6 four std", 4'b1111, 1'b0, 1'b0, 20);
        run_set("R4 R7 four dig", 4'b1111, 1'b1, 1'b0, 21);
        run_set("R4 R8 four ovr", 4'b1111, 1'b0, 1'b1, 22);
        run_set("R4 R9 four both", 4'b1111, 1'b1, 1'b1, 23);
        // R5 extremes of the sample range in every mode
        for (int md = 0; md < 4; md++) begin
            cfg_chan_en = 4'b1111; cfg_dig_en = md[0]; cfg_ovr_en = md[1];
            smp[0] = 12'h800; smp[1] = 12'h7FF; smp[2] = 12'h000; smp[3] = 12'hFFF;
            for (int c = 0; c < 4; c++) begin dg[c] = 4'hA ^ 4'(c); ov[c] = c[0]; end
            @(negedge clk);
            build_expect(4'b1111, md[0], md[1]);
            pulse_strobe();
            drain_check("R5 extremes");
        end
    endtask

    task automatic t_bad_mask();
        logic [3:0] bad [2];
        bad[0] = 4'b0111; bad[1] = 4'b0000;
        for (int k = 0; k < 2; k++) begin
            cfg_chan_en = bad[k];
            load_set(40 + k);
            @(negedge clk);
            chk("R1 error raised", config_error, 1);
            pulse_strobe();
            for (int i = 0; i < 3; i++) begin
                chk("R1 no words", out_valid, 0);
                @(negedge clk);
            end
        end
        cfg_chan_en = 4'b0101;
        @(negedge clk);
        chk("R1 error cleared", config_error, 0);
    endtask

    task automatic t_stall();
        cfg_chan_en = 4'b1111; cfg_dig_en = 1'b1; cfg_ovr_en = 1'b0;
        load_set(50);
        @(negedge clk);
        build_expect(4'b1111, 1'b1, 1'b0);
        out_ready = 1'b0;
        pulse_strobe();
        for (int i = 0; i < 3; i++) begin
            chk("R12 stalled valid", out_valid, 1);
            chk("R12 stalled word", out_data, expw[0]);
            @(negedge clk);
        end
        // R10: change mode and mask while the set is held
        cfg_chan_en = 4'b0001; cfg_dig_en = 1'b0; cfg_ovr_en = 1'b1;
        @(negedge clk);
        out_ready = 1'b1;
        drain_check("R10 R12 after stall");
    endtask

    task automatic t_overflow();
        cfg_chan_en = 4'b1111; cfg_dig_en = 1'b0; cfg_ovr_en = 1'b0;
        load_set(60);
        @(negedge clk);
        build_expect(4'b1111, 1'b0, 1'b0);
        out_ready = 1'b0;
        pulse_strobe();
        chk("R11 before second strobe", overflow, 0);
        load_set(61);
        pulse_strobe();
        chk("R11 overflow set", overflow, 1);
        out_ready = 1'b1;
        drain_check("R11 first set kept");
        repeat (3) begin
            chk("R11 dropped set silent", out_valid, 0);
            chk("R11 overflow sticky", overflow, 1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        load_set(0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_pairs();
        t_four_modes();
        t_bad_mask();
        t_stall();
        t_overflow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule